// File: doc/BRIEF.md
# Compact Category-Decoded Processor Core

This block is a single-issue processor core that finishes one instruction in every clock cycle. It runs a reduced integer instruction set. Each 32-bit word is decoded by a 2-bit category field in bits [1:0] and a 5-bit opcode in bits [6:2]. The core holds a 32-entry register file and a program counter. Both are cleared by reset, and the program counter restarts at byte address 256.

The instruction memory and the data memory are external. Both are read combinationally: the core presents an address and uses the returned word in the same cycle. A store is written by the memory on the next rising edge while the store enable is high.

Each cycle in which the core is running, it reports the program counter and the instruction word it retires on a trace port. A break instruction stops the core. From the cycle after a break retires, the halted flag is high, and it stays high until reset.

Top module: `cat_core`

## Requirements
- R1: While reset is low and in the first cycle after it is released, the program counter is 256 and halted is low. In that first cycle after release, the trace reports pc 256.
- R2: Category 01 (bits [1:0]=01) executes register-register operations, writing rd (bits [11:7]) from rs1 (bits [19:15]) and rs2 (bits [24:20]). The opcodes in bits [6:2] are 00000 add and 00001 sub, both 32-bit two's complement, and 00010 and and 00011 or, both bitwise.
- R3: Category 10 with opcodes 00000 addi, 00001 andi and 00010 ori combines rs1 with the 12-bit immediate in bits [31:20], sign-extended to 32 bits.
- R4: Category 10 opcode 00011 (sll) shifts rs1 left logically and opcode 00100 (sra) shifts it right arithmetically. In both cases only the low 5 bits of the immediate give the shift amount.
- R5: Register x0 always reads as zero, and any write to it is discarded.
- R6: Category 10 opcode 00101 (lw) loads rd from the data word at rs1 plus the sign-extended immediate in bits [31:20]. Category 00 opcode 00011 (sw) writes rs2 to the address rs1 plus the sign-extended immediate {bits [31:25], bits [11:7]}, with the store enable high for that cycle only.
- R7: Category 00 opcodes 00000 beq, 00001 bne and 00010 blt (signed less-than) compare rs1 with rs2. A taken branch goes to its own address plus the 12-bit value {bits [31:25], bits [11:7]} shifted left by one and sign-extended. A branch that is not taken goes to the next word.
- R8: Category 11 opcode 00000 (jal) jumps to its own address plus the 20-bit value in bits [31:12] shifted left by one and sign-extended. It writes its own address plus 4 to rd, for any rd.
- R9: Every cycle that the core is out of reset and not halted, it retires exactly one instruction. The trace valid signal is high, with the pc and the instruction word. Any instruction that is not a taken branch, jal or break is followed by the instruction at pc+4.
- R10: When break (category 11, opcode 11111) retires, halted rises on the next cycle and stays high until reset. While halted, nothing retires, no store is issued and the program counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Byte address of the current instruction |
| imem_rdata | input | 32 | Instruction word at imem_addr, available in the same cycle |
| dmem_addr | output | 32 | Byte address for a load or a store |
| dmem_wdata | output | 32 | Data to store |
| dmem_we | output | 1 | Store enable, written at the next rising edge |
| dmem_rdata | input | 32 | Data word at dmem_addr, available in the same cycle |
| halted | output | 1 | High once break has retired, until reset |
| retire_valid | output | 1 | An instruction retires this cycle |
| retire_pc | output | 32 | Address of the retiring instruction |
| retire_instr | output | 32 | Word of the retiring instruction |

## Verification
The embedded checks assume that the instruction memory supplies the word at imem_addr within the same cycle. They also assume that every branch and jump offset in the program keeps the program counter word-aligned. The bench meets both assumptions: it serves both memories from one combinational array, and it uses only even word-multiple offsets in its three programs. Those programs cover arithmetic, logic, shifts, loads and stores, branch loops, and jumps forward and backward. A behavioural model steps alongside the core and checks the trace and every store on every cycle. After each program, the stored results are compared with values worked out by hand.

// File: rtl/cat_core.sv
module cat_core #(
  parameter logic [31:0] RESET_PC = 32'd256
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic        halted,
  output logic        retire_valid,
  output logic [31:0] retire_pc,
  output logic [31:0] retire_instr
);
  localparam int NREG = 32;

  logic [31:0] pc_q;
  logic        halted_q;
  logic [31:0] rf [NREG];

  logic [31:0] ins;
  logic [1:0]  cat;
  logic [4:0]  op, rd, rs1, rs2;
  logic [31:0] a, b, imm_i, imm_s, br_off, j_off;
  logic [31:0] next_pc, wb_val;
  logic        wb_en, store, brk, run;
  logic        unused_func3;

  assign ins   = imem_rdata;
  assign cat   = ins[1:0];
  assign op    = ins[6:2];
  assign rd    = ins[11:7];
  assign rs1   = ins[19:15];
  assign rs2   = ins[24:20];
  assign unused_func3 = ^ins[14:12];

  assign a      = (rs1 == 5'd0) ? 32'd0 : rf[rs1];
  assign b      = (rs2 == 5'd0) ? 32'd0 : rf[rs2];
  assign imm_i  = {{20{ins[31]}}, ins[31:20]};
  assign imm_s  = {{20{ins[31]}}, ins[31:25], ins[11:7]};
  assign br_off = {{19{ins[31]}}, ins[31:25], ins[11:7], 1'b0};
  assign j_off  = {{11{ins[31]}}, ins[31:12], 1'b0};

  assign run = rst_n && !halted_q;

  always_comb begin
    next_pc = pc_q + 32'd4;
    wb_en   = 1'b0;
    wb_val  = 32'd0;
    store   = 1'b0;
    brk     = 1'b0;
    case (cat)
      2'b00: case (op)
        5'd0: if (a == b) next_pc = pc_q + br_off;
        5'd1: if (a != b) next_pc = pc_q + br_off;
        5'd2: if ($signed(a) < $signed(b)) next_pc = pc_q + br_off;
        5'd3: store = 1'b1;
        default: ;
      endcase
      2'b01: begin
        wb_en = 1'b1;
        case (op)
          5'd0: wb_val = a + b;
          5'd1: wb_val = a - b;
          5'd2: wb_val = a & b;
          5'd3: wb_val = a | b;
          default: wb_en = 1'b0;
        endcase
      end
      2'b10: begin
        wb_en = 1'b1;
        case (op)
          5'd0: wb_val = a + imm_i;
          5'd1: wb_val = a & imm_i;
          5'd2: wb_val = a | imm_i;
          5'd3: wb_val = a << imm_i[4:0];
          5'd4: wb_val = $signed(a) >>> imm_i[4:0];
          5'd5: wb_val = dmem_rdata;
          default: wb_en = 1'b0;
        endcase
      end
      default: case (op)
        5'd0: begin
          wb_en   = 1'b1;
          wb_val  = pc_q + 32'd4;
          next_pc = pc_q + j_off;
        end
        5'd31: begin
          brk     = 1'b1;
          next_pc = pc_q;
        end
        default: ;
      endcase
    endcase
  end

  assign imem_addr    = pc_q;
  assign dmem_addr    = a + ((cat == 2'b00) ? imm_s : imm_i);
  assign dmem_wdata   = b;
  assign dmem_we      = run && store;
  assign halted       = halted_q;
  assign retire_valid = run;
  assign retire_pc    = pc_q;
  assign retire_instr = ins;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      halted_q <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= 32'd0;
    end else if (run) begin
      pc_q     <= next_pc;
      halted_q <= brk;
      if (wb_en && rd != 5'd0) rf[rd] <= wb_val;
    end
  end

  AST_BREAK_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && retire_instr[1:0] == 2'b11 && retire_instr[6:2] == 5'd31) |=> halted); // R10
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R10
  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(imem_addr)); // R10
  AST_NO_STORE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!dmem_we && !retire_valid)); // R10
  AST_SEQ_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && retire_instr[1:0] == 2'b01) |=> (retire_pc == $past(retire_pc) + 32'd4)); // R9
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[1:0] == 2'b00); // R9
endmodule

// File: tb/tb_cat_core.sv
module tb_cat_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, halted, retire_valid;
  logic [31:0] retire_pc, retire_instr;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] mem  [512];
  logic [31:0] mmem [512];
  int          mregs [32];
  logic [31:0] mpc;
  bit          mhalt;
  int          pidx;

  always #10 clk = ~clk;

  cat_core dut (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .halted(halted),
    .retire_valid(retire_valid), .retire_pc(retire_pc), .retire_instr(retire_instr)
  );

  assign imem_rdata = mem[imem_addr[10:2]];
  assign dmem_rdata = mem[dmem_addr[10:2]];
  always @(posedge clk) if (dmem_we) mem[dmem_addr[10:2]] <= dmem_wdata;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [4:0] op, logic [4:0] rd, logic [4:0] s1, logic [4:0] s2);
    return {7'b0, s2, s1, 3'b0, rd, op, 2'b01};
  endfunction
  function automatic logic [31:0] enc_i(logic [4:0] op, logic [4:0] rd, logic [4:0] s1, int imm);
    logic [31:0] v = imm;
    return {v[11:0], s1, 3'b0, rd, op, 2'b10};
  endfunction
  function automatic logic [31:0] enc_s(logic [4:0] op, logic [4:0] s1, logic [4:0] s2, int imm);
    logic [31:0] v = imm;
    return {v[11:5], s2, s1, 3'b0, v[4:0], op, 2'b00};
  endfunction
  function automatic logic [31:0] enc_b(logic [4:0] op, logic [4:0] s1, logic [4:0] s2, int off);
    return enc_s(op, s1, s2, off / 2);
  endfunction
  function automatic logic [31:0] enc_j(logic [4:0] rd, int off);
    logic [31:0] v = off / 2;
    return {v[19:0], rd, 5'd0, 2'b11};
  endfunction
  localparam logic [31:0] BRK = {20'd0, 5'd0, 5'd31, 2'b11};

  function automatic string tag_of(logic [31:0] w);
    case (w[1:0])
      2'b00: return (w[6:2] == 5'd3) ? "R6" : "R7";
      2'b01: return "R2";
      2'b10: return (w[6:2] <= 5'd2) ? "R3" : (w[6:2] <= 5'd4) ? "R4" : "R6";
      default: return (w[6:2] == 5'd0) ? "R8" : "R10";
    endcase
  endfunction

  task automatic put(logic [31:0] w);
    mem[pidx] = w; mmem[pidx] = w; pidx++;
  endtask
  task automatic poke(int byte_addr, logic [31:0] w);
    mem[byte_addr / 4] = w; mmem[byte_addr / 4] = w;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 512; i++) begin mem[i] = 32'd0; mmem[i] = 32'd0; end
    pidx = 64;
  endtask

  task automatic model_cycle();
    logic [31:0] w = mmem[mpc[10:2]];
    string t = tag_of(w);
    int a, b, ii, is, br, jo, res;
    bit wr = 0, st = 0;
    logic [31:0] npc = mpc + 4;
    logic [4:0] o = w[6:2];
    a  = (w[19:15] == 0) ? 0 : mregs[w[19:15]];
    b  = (w[24:20] == 0) ? 0 : mregs[w[24:20]];
    ii = int'($signed(w[31:20]));
    is = int'($signed({w[31:25], w[11:7]}));
    br = is * 2;
    jo = int'($signed(w[31:12])) * 2;
    res = 0;
    case (w[1:0])
      2'b00: begin
        if (o == 0 && a == b) npc = mpc + br;
        if (o == 1 && a != b) npc = mpc + br;
        if (o == 2 && a < b)  npc = mpc + br;
        if (o == 3) st = 1;
      end
      2'b01: begin
        wr = 1;
        if (o == 0) res = a + b; else if (o == 1) res = a - b;
        else if (o == 2) res = a & b; else res = a | b;
      end
      2'b10: begin
        wr = 1;
        case (o)
          0: res = a + ii;
          1: res = a & ii;
          2: res = a | ii;
          3: res = a << (ii & 31);
          4: res = a >>> (ii & 31);
          default: res = mmem[((a + ii) >> 2) & 511];
        endcase
      end
      default: begin
        if (o == 0) begin wr = 1; res = mpc + 4; npc = mpc + jo; end
        else begin mhalt = 1; npc = mpc; end
      end
    endcase
    chk("R9", "retire_valid", {31'd0, retire_valid}, 32'd1);
    chk("R10", "halted low while running", {31'd0, halted}, 32'd0);
    chk(t, "retire_pc", retire_pc, mpc);
    chk(t, "retire_instr", retire_instr, w);
    chk(t, "store enable", {31'd0, dmem_we}, {31'd0, st});
    if (st) begin
      chk("R6", "store addr", dmem_addr, a + is);
      chk("R6", "store data", dmem_wdata, b);
      mmem[((a + is) >> 2) & 511] = b;
    end
    if (wr && w[11:7] != 0) mregs[w[11:7]] = res;
    mpc = npc;
  endtask

  task automatic run_prog();
    for (int i = 0; i < 32; i++) mregs[i] = 0;
    mpc = 32'd256; mhalt = 0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #5;
    chk("R1", "pc in reset", imem_addr, 32'd256);
    chk("R1", "halted in reset", {31'd0, halted}, 32'd0);
    rst_n = 1'b1;
    #2;
    chk("R1", "first trace pc", retire_pc, 32'd256);
    chk("R1", "halted after release", {31'd0, halted}, 32'd0);
    for (int c = 0; c < 400 && !mhalt; c++) begin
      model_cycle();
      @(posedge clk); #5;
    end
    for (int k = 0; k < 4; k++) begin
      chk("R10", "halted", {31'd0, halted}, 32'd1);
      chk("R10", "no retire", {31'd0, retire_valid}, 32'd0);
      chk("R10", "no store", {31'd0, dmem_we}, 32'd0);
      chk("R10", "pc frozen", imem_addr, mpc);
      @(posedge clk); #5;
    end
    for (int i = 0; i < 512; i++)
      if (mem[i] !== mmem[i]) chk("R9", $sformatf("memory word %0d vs model", i), mem[i], mmem[i]);
  endtask

  initial begin
    @(negedge clk);
    // Program A: arithmetic, logic, shifts, x0, loads, stores
    clear_all();
    put(enc_i(0, 1, 0, 100));
    put(enc_i(0, 2, 0, -7));
    put(enc_r(0, 3, 1, 2));
    put(enc_r(1, 4, 2, 1));
    put(enc_r(2, 5, 1, 2));
    put(enc_r(3, 6, 1, 2));
    put(enc_i(1, 7, 2, 32'h0F0));
    put(enc_i(2, 8, 1, -256));
    put(enc_i(3, 9, 2, 4));
    put(enc_i(4, 10, 2, 1));
    put(enc_i(4, 11, 4, 32'h7E3));
    put(enc_i(0, 0, 1, 5));
    put(enc_r(0, 17, 0, 1));
    put(enc_i(5, 12, 0, 768));
    put(enc_i(0, 13, 0, 800));
    put(enc_i(5, 14, 13, -28));
    put(enc_i(0, 15, 0, 1024));
    for (int r = 3; r <= 12; r++) put(enc_s(3, 15, r[4:0], (r - 3) * 4));
    put(enc_s(3, 15, 14, 40));
    put(enc_s(3, 15, 0, 44));
    put(enc_s(3, 15, 17, 48));
    put(BRK);
    put(enc_s(3, 15, 1, 64));
    poke(768, 32'h12345678);
    poke(772, 32'hFFFFFFFB);
    poke(1068, 32'h00000055);
    run_prog();
    chk("R2", "add", mem[256], 32'd93);
    chk("R2", "sub", mem[257], -32'sd107);
    chk("R2", "and", mem[258], 32'd96);
    chk("R2", "or", mem[259], 32'hFFFFFFFD);
    chk("R3", "andi", mem[260], 32'd240);
    chk("R3", "ori sign-extended", mem[261], 32'hFFFFFF64);
    chk("R4", "sll", mem[262], -32'sd112);
    chk("R4", "sra", mem[263], -32'sd4);
    chk("R4", "sra low five bits", mem[264], -32'sd14);
    chk("R6", "lw", mem[265], 32'h12345678);
    chk("R6", "lw negative offset", mem[266], 32'hFFFFFFFB);
    chk("R5", "sw x0 stores zero", mem[267], 32'd0);
    chk("R5", "x0 write discarded", mem[268], 32'd100);
    chk("R10", "store after break not done", mem[272], 32'd0);

    // Program B: branches
    clear_all();
    put(enc_i(0, 1, 0, 0));
    put(enc_i(0, 2, 0, 5));
    put(enc_i(0, 1, 1, 1));
    put(enc_b(1, 1, 2, -4));
    put(enc_b(0, 1, 2, 8));
    put(enc_i(0, 3, 0, 99));
    put(enc_i(0, 4, 0, -1));
    put(enc_b(2, 4, 0, 8));
    put(enc_i(0, 5, 0, 77));
    put(enc_b(2, 0, 4, 8));
    put(enc_i(0, 6, 0, 33));
    put(enc_b(0, 1, 0, 8));
    put(enc_i(0, 7, 0, 44));
    put(enc_s(3, 0, 1, 1024));
    put(enc_s(3, 0, 3, 1028));
    put(enc_s(3, 0, 5, 1032));
    put(enc_s(3, 0, 6, 1036));
    put(enc_s(3, 0, 7, 1040));
    put(BRK);
    run_prog();
    chk("R7", "bne loop count", mem[256], 32'd5);
    chk("R7", "beq taken skip", mem[257], 32'd0);
    chk("R7", "blt signed taken", mem[258], 32'd0);
    chk("R7", "blt not taken", mem[259], 32'd33);
    chk("R7", "beq not taken", mem[260], 32'd44);

    // Program C: jal forward and backward, various rd
    clear_all();
    put(enc_i(0, 1, 0, 0));
    put(enc_j(5, 12));
    put(enc_i(0, 1, 0, 11));
    put(enc_i(0, 1, 0, 22));
    put(enc_i(0, 2, 0, 3));
    put(enc_j(6, 12));
    put(enc_i(0, 3, 0, 7));
    put(enc_j(0, 12));
    put(enc_j(7, -8));
    put(enc_i(0, 3, 0, 55));
    put(enc_s(3, 0, 1, 1024));
    put(enc_s(3, 0, 2, 1028));
    put(enc_s(3, 0, 3, 1032));
    put(enc_s(3, 0, 5, 1036));
    put(enc_s(3, 0, 6, 1040));
    put(enc_s(3, 0, 7, 1044));
    put(BRK);
    run_prog();
    chk("R8", "skipped by jal", mem[256], 32'd0);
    chk("R8", "jal target reached", mem[257], 32'd3);
    chk("R8", "backward jal path", mem[258], 32'd7);
    chk("R8", "link x5", mem[259], 32'd264);
    chk("R8", "link x6", mem[260], 32'd280);
    chk("R8", "link x7", mem[261], 32'd292);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule